// File: doc/BRIEF.md
# Host Bus Slave with Sticky Transfer-Error Tracking

This block sits between an 8-bit microcontroller bus and the voice-data path of a recording and playback engine. The host selects the slave with an active-low chip select. A data/command select line and two active-low strobes, one for read and one for write, control each access. With the select high, a write places a byte in the playback FIFO and a read takes a byte from the recording FIFO. With the select low, a write loads the command register and a read returns a status byte.

The bus pins are asynchronous to the block clock. A synchronizer resamples them, and each access takes effect once, when its strobe returns high. The block watches four kinds of misuse: reading an empty recording FIFO, writing a full playback FIFO, writing a command while the command processor cannot accept it, and an internal record write that finds the recording FIFO full. Each kind keeps its own sticky cause bit, and only the matching normal transfer clears it. The host sees the OR of the four bits as one error flag, both on a pin and in the status byte.

Top module: `hostbus_if`

## Requirements
- R1: A strobe release is acted on only if the synchronized chip select is low at that moment. With chip select high, no FIFO strobe, no command load, no command register change and no error-flag change occurs.
- R2: A data write (select = 1) with the playback FIFO not full produces exactly one `play_push` pulse, and `play_wdata` carries the written byte.
- R3: During a data read (select = 1), `bus_dout` shows `rec_rdata`. Releasing the read strobe with the recording FIFO not empty produces exactly one `rec_pop` pulse.
- R4: A command write (select = 0) while `cmd_ready` is high loads the byte into `cmd_reg` and produces exactly one `cmd_load` pulse. A status read (select = 0) has no side effect.
- R5: With select = 0, `bus_dout` is the status byte. Bit 7 is `run_active` and bit 5 is `run_paused`. Bits 6 and 4 read 0. Bits 3, 2 and 1 are the empty, half and full flags of the FIFO chosen by `flag_sel` (0 = playback, 1 = recording). Bit 0 is the error flag.
- R6: With `flag_pol` = 1, status bits 3 to 1 are active high. With `flag_pol` = 0, they are the inverse of the flags.
- R7: The error flag sets on each of four causes: a data read with `rec_empty` high, a data write with `play_full` high, a command write with `cmd_ready` low, and a `rec_wr_req` cycle with `rec_full` high. A rejected access produces no FIFO pulse and leaves `cmd_reg` unchanged.
- R8: Each cause is cleared only by its own normal event: a data read with `rec_empty` low, a data write with `play_full` low, a command write with `cmd_ready` high, or a `rec_wr_req` cycle with `rec_full` low. The flag stays high while any cause is pending.
- R9: Each access is handled once. It takes effect within four clock cycles of the strobe returning high, provided chip select, select and data stay stable for that window.
- R10: Reset clears `cmd_reg` and the error flag and produces no strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| dc_sel | input | 1 | 1 = voice data, 0 = command/status |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data or status to the host |
| rec_rdata | input | 8 | Head byte of the recording FIFO |
| rec_pop | output | 1 | One-cycle pop of the recording FIFO |
| play_wdata | output | 8 | Byte for the playback FIFO |
| play_push | output | 1 | One-cycle push into the playback FIFO |
| cmd_reg | output | 8 | Last accepted command byte |
| cmd_load | output | 1 | One-cycle pulse when a command is accepted |
| cmd_ready | input | 1 | Command processor can accept a command |
| rec_wr_req | input | 1 | Internal record engine write attempt |
| play_empty | input | 1 | Playback FIFO empty |
| play_half | input | 1 | Playback FIFO more than half full |
| play_full | input | 1 | Playback FIFO full |
| rec_empty | input | 1 | Recording FIFO empty |
| rec_half | input | 1 | Recording FIFO more than half full |
| rec_full | input | 1 | Recording FIFO full |
| flag_sel | input | 1 | FIFO shown in status: 0 playback, 1 recording |
| flag_pol | input | 1 | Status flag polarity: 1 active high |
| run_active | input | 1 | Recording or playback in progress |
| run_paused | input | 1 | Playback paused |
| xfer_err | output | 1 | Sticky transfer-error flag |

## Verification
The hardest case to reach from the ports is two or more error causes pending at the same time. The single visible flag must then stay high until every cause has seen its own normal event. The stimulus walks through every ordered pair of causes. It raises one cause, then applies the normal event of each other cause and checks that the flag stays set. Finally it applies the matching normal event and checks that the flag drops. Around this, sweeps write all 256 data and command byte values, and go through every combination of the status inputs and the polarity setting.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  // status byte bit positions (host software decodes these)
  localparam int ST_RUN   = 7;
  localparam int ST_PAUSE = 5;
  localparam int ST_EMPTY = 3;
  localparam int ST_HALF  = 2;
  localparam int ST_FULL  = 1;
  localparam int ST_ERR   = 0;

  localparam int BYTE_W   = 8;
  localparam int NCAUSE   = 4;

  // index of each error cause in the cause vector
  localparam int C_RD_EMPTY = 0;
  localparam int C_WR_FULL  = 1;
  localparam int C_CMD_BUSY = 2;
  localparam int C_REC_OVF  = 3;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hb_err_track.sv
module hb_err_track
  import hostbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] set_v,
  input  logic [NCAUSE-1:0] clr_v,
  output logic              err_any
);
  logic [NCAUSE-1:0] cause_q;
  logic [NCAUSE-1:0] cause_d;

  generate
    for (genvar c = 0; c < NCAUSE; c++) begin : g_cause
      always_comb begin
        if (set_v[c])      cause_d[c] = 1'b1;
        else if (clr_v[c]) cause_d[c] = 1'b0;
        else               cause_d[c] = cause_q[c];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign err_any = |cause_q;
endmodule

// File: rtl/hb_status.sv
module hb_status
  import hostbus_pkg::*;
(
  input  logic              run_active,
  input  logic              run_paused,
  input  logic              flag_sel,
  input  logic              flag_pol,
  input  logic [2:0]        play_flags,
  input  logic [2:0]        rec_flags,
  input  logic              err,
  output logic [BYTE_W-1:0] status
);
  logic [2:0] chosen;
  logic [2:0] shown;

  always_comb begin
    chosen = flag_sel ? rec_flags : play_flags;
    shown  = flag_pol ? chosen : ~chosen;
    status = '0;
    status[ST_RUN]   = run_active;
    status[ST_PAUSE] = run_paused;
    status[ST_EMPTY] = shown[2];
    status[ST_HALF]  = shown[1];
    status[ST_FULL]  = shown[0];
    status[ST_ERR]   = err;
  end
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
  import hostbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              dc_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  input  logic [BYTE_W-1:0] rec_rdata,
  output logic              rec_pop,
  output logic [BYTE_W-1:0] play_wdata,
  output logic              play_push,
  output logic [BYTE_W-1:0] cmd_reg,
  output logic              cmd_load,
  input  logic              cmd_ready,
  input  logic              rec_wr_req,
  input  logic              play_empty,
  input  logic              play_half,
  input  logic              play_full,
  input  logic              rec_empty,
  input  logic              rec_half,
  input  logic              rec_full,
  input  logic              flag_sel,
  input  logic              flag_pol,
  input  logic              run_active,
  input  logic              run_paused,
  output logic              xfer_err
);
  localparam int NPIN = 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // bus pin synchronizer: {cs_n, dc_sel, rd_n, wr_n}, idle = 1,0,1,1
  logic [NPIN-1:0] pins_s;
  hb_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)) u_sync (
    .clk(clk), .rst_n(srst_n),
    .d({cs_n, dc_sel, rd_n, wr_n}), .q(pins_s)
  );
  logic cs_s, dc_s, rd_s, wr_s;
  assign {cs_s, dc_s, rd_s, wr_s} = pins_s;

  // strobe release detection
  logic rd_prev_q, wr_prev_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
    end else begin
      rd_prev_q <= rd_s;
      wr_prev_q <= wr_s;
    end
  end

  logic rd_ev, wr_ev, data_wr, cmd_wr, data_rd;
  assign rd_ev   = rd_s & ~rd_prev_q & ~cs_s;
  assign wr_ev   = wr_s & ~wr_prev_q & ~cs_s;
  assign data_wr = wr_ev &  dc_s;
  assign cmd_wr  = wr_ev & ~dc_s;
  assign data_rd = rd_ev &  dc_s;

  // misuse / normal classification per cause
  logic [NCAUSE-1:0] set_v, clr_v;
  always_comb begin
    set_v[C_RD_EMPTY] = data_rd & rec_empty;
    clr_v[C_RD_EMPTY] = data_rd & ~rec_empty;
    set_v[C_WR_FULL]  = data_wr & play_full;
    clr_v[C_WR_FULL]  = data_wr & ~play_full;
    set_v[C_CMD_BUSY] = cmd_wr & ~cmd_ready;
    clr_v[C_CMD_BUSY] = cmd_wr & cmd_ready;
    set_v[C_REC_OVF]  = rec_wr_req & rec_full;
    clr_v[C_REC_OVF]  = rec_wr_req & ~rec_full;
  end

  hb_err_track u_err (
    .clk(clk), .rst_n(srst_n), .set_v(set_v), .clr_v(clr_v), .err_any(xfer_err)
  );

  // side effects: next state
  logic              push_d, pop_d, load_d;
  logic [BYTE_W-1:0] wdata_d, cmd_d;
  always_comb begin
    push_d  = clr_v[C_WR_FULL];
    pop_d   = clr_v[C_RD_EMPTY];
    load_d  = clr_v[C_CMD_BUSY];
    wdata_d = push_d ? bus_din : play_wdata;
    cmd_d   = load_d ? bus_din : cmd_reg;
  end

  // side effects: registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      play_push  <= 1'b0;
      rec_pop    <= 1'b0;
      cmd_load   <= 1'b0;
      play_wdata <= '0;
      cmd_reg    <= '0;
    end else begin
      play_push  <= push_d;
      rec_pop    <= pop_d;
      cmd_load   <= load_d;
      play_wdata <= wdata_d;
      cmd_reg    <= cmd_d;
    end
  end

  // read path
  logic [BYTE_W-1:0] status;
  hb_status u_status (
    .run_active(run_active), .run_paused(run_paused),
    .flag_sel(flag_sel), .flag_pol(flag_pol),
    .play_flags({play_empty, play_half, play_full}),
    .rec_flags({rec_empty, rec_half, rec_full}),
    .err(xfer_err), .status(status)
  );

  assign bus_dout = dc_s ? rec_rdata : status;
endmodule

// File: rtl/hostbus_if_chk.sv
module hostbus_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       play_push,
  input logic       rec_pop,
  input logic       cmd_load,
  input logic [7:0] cmd_reg,
  input logic       play_full,
  input logic       rec_empty
);
  // R2
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_push |-> !$past(play_full));

  // R3
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_pop |-> !$past(rec_empty));

  // R4
  cmd_change_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reg != $past(cmd_reg)) |-> cmd_load);

  // R9
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({play_push, rec_pop, cmd_load}));

  // R9
  push_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_push |=> !play_push);

  // R9
  pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_pop |=> !rec_pop);
endmodule

bind hostbus_if hostbus_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .play_push(play_push), .rec_pop(rec_pop),
  .cmd_load(cmd_load), .cmd_reg(cmd_reg), .play_full(play_full),
  .rec_empty(rec_empty)
);

// File: tb/hostbus_if_tb.sv
module hostbus_if_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, dc_sel, rd_n, wr_n;
  logic [7:0] bus_din, bus_dout, rec_rdata, play_wdata, cmd_reg;
  logic rec_pop, play_push, cmd_load, cmd_ready, rec_wr_req;
  logic play_empty, play_half, play_full, rec_empty, rec_half, rec_full;
  logic flag_sel, flag_pol, run_active, run_paused, xfer_err;

  hostbus_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dc_sel(dc_sel), .rd_n(rd_n),
    .wr_n(wr_n), .bus_din(bus_din), .bus_dout(bus_dout), .rec_rdata(rec_rdata),
    .rec_pop(rec_pop), .play_wdata(play_wdata), .play_push(play_push),
    .cmd_reg(cmd_reg), .cmd_load(cmd_load), .cmd_ready(cmd_ready),
    .rec_wr_req(rec_wr_req), .play_empty(play_empty), .play_half(play_half),
    .play_full(play_full), .rec_empty(rec_empty), .rec_half(rec_half),
    .rec_full(rec_full), .flag_sel(flag_sel), .flag_pol(flag_pol),
    .run_active(run_active), .run_paused(run_paused), .xfer_err(xfer_err)
  );

  int total = 0;
  int bad = 0;
  int n_push = 0, n_pop = 0, n_load = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (play_push) n_push++;
    if (rec_pop)   n_pop++;
    if (cmd_load)  n_load++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    cs_n = 1; dc_sel = 0; rd_n = 1; wr_n = 1; bus_din = 0;
    cmd_ready = 1; rec_wr_req = 0;
    play_empty = 0; play_half = 0; play_full = 0;
    rec_empty = 0; rec_half = 0; rec_full = 0;
  endtask

  // one bus access; returns bus_dout sampled while strobe is low
  task automatic bus_xfer(input logic csn, input logic dcv, input bit is_wr,
                          input logic [7:0] b, output logic [7:0] seen);
    @(negedge clk);
    cs_n = csn; dc_sel = dcv; bus_din = b;
    if (is_wr) wr_n = 0; else rd_n = 0;
    repeat (3) @(negedge clk);
    seen = bus_dout;
    wr_n = 1; rd_n = 1;
    repeat (5) @(negedge clk);
    cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  // cause 0 data read, 1 data write, 2 command write, 3 internal record write
  task automatic do_case(input int c, input bit misuse, input logic [7:0] b);
    logic [7:0] s;
    case (c)
      0: begin rec_empty = misuse;  bus_xfer(0, 1, 0, b, s); rec_empty = 0; end
      1: begin play_full = misuse;  bus_xfer(0, 1, 1, b, s); play_full = 0; end
      2: begin cmd_ready = !misuse; bus_xfer(0, 0, 1, b, s); cmd_ready = 1; end
      default: begin
        @(negedge clk); rec_full = misuse; rec_wr_req = 1;
        @(negedge clk); rec_wr_req = 0; rec_full = 0;
        repeat (2) @(negedge clk);
      end
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] s;
    int p0, q0, l0;
    logic [7:0] c0;
    set_idle();
    flag_sel = 0; flag_pol = 1; run_active = 0; run_paused = 0; rec_rdata = 8'h00;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(cmd_reg == 0 && xfer_err == 0 && !play_push && !rec_pop && !cmd_load,
          "R10 reset state", {cmd_reg, xfer_err}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(n_push + n_pop + n_load == 0, "R10 no pulses", n_push + n_pop + n_load, 0);

    // R5 R6 status sweep
    dc_sel = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 1024; i++) begin
      logic [2:0] pf, rf, ch;
      logic [7:0] exp;
      @(negedge clk);
      run_active = i[0]; run_paused = i[1]; flag_sel = i[2]; flag_pol = i[3];
      pf = i[6:4]; rf = i[9:7];
      {play_empty, play_half, play_full} = pf;
      {rec_empty, rec_half, rec_full} = rf;
      #1;
      ch = i[2] ? rf : pf;
      if (!i[3]) ch = ~ch;
      exp = {i[0], 1'b0, i[1], 1'b0, ch, 1'b0};
      check(bus_dout == exp, i[3] ? "R5 status" : "R6 polarity", bus_dout, exp);
    end
    set_idle(); flag_sel = 0; flag_pol = 1; run_active = 0; run_paused = 0;
    repeat (2) @(negedge clk);

    // R2 R9 all data bytes
    for (int b = 0; b < 256; b++) begin
      p0 = n_push;
      bus_xfer(0, 1, 1, b[7:0], s);
      check(n_push == p0 + 1 && play_wdata == b[7:0], "R2 R9 data write",
            {n_push - p0, play_wdata}, {1, b[7:0]});
    end
    // R4 all command bytes, and status read has no effect
    for (int b = 0; b < 256; b++) begin
      l0 = n_load;
      bus_xfer(0, 0, 1, b[7:0], s);
      check(n_load == l0 + 1 && cmd_reg == b[7:0], "R4 cmd write",
            {n_load - l0, cmd_reg}, {1, b[7:0]});
    end
    p0 = n_push; q0 = n_pop; l0 = n_load;
    bus_xfer(0, 0, 0, 8'h00, s);
    check(n_push == p0 && n_pop == q0 && n_load == l0 && cmd_reg == 8'hff,
          "R4 status read no effect", cmd_reg, 8'hff);

    // R3 data reads
    for (int b = 0; b < 8; b++) begin
      q0 = n_pop;
      rec_rdata = 8'h5a ^ (b[7:0] << 3);
      bus_xfer(0, 1, 0, 8'h00, s);
      check(s == rec_rdata && n_pop == q0 + 1, "R3 data read",
            {s, 8'(n_pop - q0)}, {rec_rdata, 8'h01});
    end

    // R1 chip select high: nothing happens, even with misuse conditions
    p0 = n_push; q0 = n_pop; l0 = n_load; c0 = cmd_reg;
    play_full = 1; rec_empty = 1; cmd_ready = 0;
    bus_xfer(1, 1, 1, 8'h11, s);
    bus_xfer(1, 1, 0, 8'h22, s);
    bus_xfer(1, 0, 1, 8'h33, s);
    set_idle();
    check(n_push == p0 && n_pop == q0 && n_load == l0 && cmd_reg == c0 && !xfer_err,
          "R1 deselected", {cmd_reg, xfer_err}, {c0, 1'b0});

    // R7 R8 every ordered pair of causes
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] v;
        v = 8'h40 + 8'(a * 4 + b);
        p0 = n_push; q0 = n_pop; l0 = n_load; c0 = cmd_reg;
        do_case(a, 1, v);
        check(xfer_err && n_push == p0 && n_pop == q0 && n_load == l0 && cmd_reg == c0,
              "R7 misuse sets, no side effect", {xfer_err, cmd_reg}, {1'b1, c0});
        dc_sel = 0;
        repeat (4) @(negedge clk);
        check(bus_dout[0] == 1'b1, "R5 status err bit", bus_dout, 1);
        if (b != a) begin
          do_case(b, 0, v);
          check(xfer_err == 1'b1, "R8 other normal keeps flag", xfer_err, 1);
        end
        p0 = n_push; q0 = n_pop; l0 = n_load;
        do_case(a, 0, v);
        check(xfer_err == 1'b0, "R8 matching normal clears", xfer_err, 0);
        if (a == 1) check(n_push == p0 + 1 && play_wdata == v, "R2 after clear", play_wdata, v);
        if (a == 2) check(n_load == l0 + 1 && cmd_reg == v, "R4 after clear", cmd_reg, v);
        if (a == 0) check(n_pop == q0 + 1, "R3 after clear", n_pop - q0, 1);
      end
    end

    // R8 two causes pending: clearing one keeps the flag
    do_case(1, 1, 8'h00);
    do_case(3, 1, 8'h00);
    do_case(1, 0, 8'h77);
    check(xfer_err == 1'b1, "R8 second cause pending", xfer_err, 1);
    do_case(3, 0, 8'h00);
    check(xfer_err == 1'b0, "R8 all causes cleared", xfer_err, 0);

    // R10 reset mid-run clears command and error
    do_case(2, 0, 8'ha5);
    do_case(0, 1, 8'h00);
    check(xfer_err && cmd_reg == 8'ha5, "R10 setup", {xfer_err, cmd_reg}, {1'b1, 8'ha5});
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(cmd_reg == 0 && xfer_err == 0, "R10 reset clears", {xfer_err, cmd_reg}, 0);

    finish_run();
  end
endmodule